// File: doc/BRIEF.md
# Program Counter Execution Sequencer

This block lets an accelerator run on its own while other masters hold the system bus. Before a job starts, bus writes load two configuration values: the first instruction address and the last one. A start command then launches the job. The sequencer drives an instruction-memory address that steps forward by one on every clock cycle.

On every cycle of a run, the sequencer compares the current address with the stored last address. Once that address has been issued, the busy flag drops and a one-cycle done pulse tells the bus wrapper that the job has finished. While the job is running, any bus access is refused with a retry indication.

A reserved command code acts as an emergency stop. It clears the stored last address to zero and ends a run at the next clock edge, so a job whose end would never be reached cannot lock up the bus.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `bus_retry` are 0, `imem_addr` is 0, and the start and end values are 0.
- R2: A write with `cfg_wr_en`=1 stores `cfg_wdata` as the start value when `cfg_sel`=0, and as the end value when `cfg_sel`=1. Such a write is accepted only while `busy`=0. A write made while `busy`=1 is ignored and does not change the current or the next run.
- R3: Command code 2'b01 on `cmd` while `busy`=0 starts a run. On the next cycle `busy`=1 and `imem_addr` equals the start value.
- R4: While `busy` stays 1 from one cycle to the next, `imem_addr` increases by exactly one per cycle.
- R5: In a busy cycle where `imem_addr` >= the end value, the next cycle has `busy`=0 and `done`=1. A run with end >= start therefore issues every address from start to end inclusive, over end-start+1 busy cycles.
- R6: If the end value is below the start value, or is zero, the run lasts exactly one busy cycle, and the address never wraps past its maximum.
- R7: `bus_retry` is 1 exactly when `bus_req`=1 while `busy`=1. It is 0 when the block is idle.
- R8: Command code 2'b11 clears the stored end value to zero. If a run is active, `busy` falls on the next cycle and `done` pulses. A later run therefore lasts a single cycle until a new end value is written.
- R9: A start command issued while `busy`=1 is ignored. The address keeps counting and does not reload.
- R10: `done` is high for exactly one cycle, in the same cycle that `busy` falls. `imem_addr` then holds the last issued address until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the start value, 1 selects the end value |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cmd | input | 2 | 00/10 none, 01 start, 11 emergency stop |
| bus_req | input | 1 | A bus access is targeting the block |
| imem_addr | output | ADDR_W | Instruction-memory address |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| bus_retry | output | 1 | Refuse the current bus access |

## Verification
On every cycle, the assertions check the following: the step-by-one address progression during a run, the start-value load after an accepted start, the one-cycle shape of the done pulse and its alignment with the falling edge of busy, the forced stop and end-value clear on the stop command, and the retry response while busy. Other behaviours involve more than one command and show only in the bench's scenarios. These are the exact run length for each start/end pair, the single-cycle runs when the end value is below the start value or is zero, the no-wrap behaviour at the top of the address range, and the fact that configuration writes made during a run leave both the current run and the next one unchanged.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_CMD_NONE  = 2'b00,
      SEQ_CMD_START = 2'b01,
      SEQ_CMD_RSVD  = 2'b10,
      SEQ_CMD_KILL  = 2'b11
   } seq_cmd_e;
endpackage

// File: rtl/pc_seq_cfg.sv
module pc_seq_cfg #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel_end,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              lock,
   input  logic              clr_end,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] last_addr
);
   logic wr_ok;
   assign wr_ok = wr_en && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_addr <= '0;
         last_addr  <= '0;
      end else begin
         if (wr_ok && !sel_end)
            first_addr <= wdata;
         if (clr_end)
            last_addr <= '0;
         else if (wr_ok && sel_end)
            last_addr <= wdata;
      end
   end
endmodule

// File: rtl/pc_seq_count.sv
module pc_seq_count #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (load)
         pc <= load_val;
      else if (step)
         pc <= pc + ADDR_W'(1);
   end
endmodule

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_cmd,
   input  logic              kill_cmd,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] last_addr,
   output logic              busy,
   output logic              done,
   output logic              load,
   output logic              step
);
   logic reached;
   logic finish;

   assign reached = (pc >= last_addr);
   assign finish  = busy && (kill_cmd || reached);
   assign load    = go_cmd && !busy;
   assign step    = busy && !finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (load)
            busy <= 1'b1;
         else if (finish)
            busy <= 1'b0;
      end
   end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pc_seq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [1:0]        cmd,
   input  logic              bus_req,
   output logic [ADDR_W-1:0] imem_addr,
   output logic              busy,
   output logic              done,
   output logic              bus_retry
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("pc_sequencer: ADDR_W must be within 2..32");
      end
   endgenerate

   logic              go_cmd, kill_cmd;
   logic              load, step;
   logic [ADDR_W-1:0] start_val, end_val;

   assign go_cmd   = (cmd == SEQ_CMD_START);
   assign kill_cmd = (cmd == SEQ_CMD_KILL);

   pc_seq_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sel_end(cfg_sel),
      .wdata(cfg_wdata), .lock(busy), .clr_end(kill_cmd),
      .first_addr(start_val), .last_addr(end_val)
   );

   pc_seq_count #(.ADDR_W(ADDR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(start_val),
      .step(step), .pc(imem_addr)
   );

   pc_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .kill_cmd(kill_cmd),
      .pc(imem_addr), .last_addr(end_val), .busy(busy), .done(done),
      .load(load), .step(step)
   );

   assign bus_retry = bus_req && busy;
endmodule

// File: rtl/pc_seq_checker.sv
module pc_seq_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd,
   input logic              bus_req,
   input logic [ADDR_W-1:0] imem_addr,
   input logic              busy,
   input logic              done,
   input logic              bus_retry,
   input logic [ADDR_W-1:0] start_val,
   input logic [ADDR_W-1:0] end_val
);
   // R4
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (imem_addr == $past(imem_addr) + ADDR_W'(1)));

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01 && !busy) |=> (busy && imem_addr == $past(start_val)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R5
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8
   kill_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b11 && busy) |=> (!busy && done && end_val == '0));

   // R7
   retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && busy) |-> bus_retry);

   // R7
   no_retry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_retry);
endmodule

bind pc_sequencer pc_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .bus_req(bus_req),
   .imem_addr(imem_addr), .busy(busy), .done(done), .bus_retry(bus_retry),
   .start_val(start_val), .end_val(end_val)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [1:0]    cmd = 2'b00;
   logic          bus_req = 1'b0;
   logic [AW-1:0] imem_addr;
   logic          busy, done, bus_retry;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   pc_sequencer #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cmd(cmd), .bus_req(bus_req),
      .imem_addr(imem_addr), .busy(busy), .done(done), .bus_retry(bus_retry)
   );

   // {start, end, expected busy cycles}
   localparam logic [23:0] VEC [0:6] = '{
      {8'd3,   8'd7,   8'd5},
      {8'd10,  8'd10,  8'd1},
      {8'd20,  8'd15,  8'd1},
      {8'd0,   8'd0,   8'd1},
      {8'd250, 8'd255, 8'd6},
      {8'd5,   8'd0,   8'd1},
      {8'd255, 8'd255, 8'd1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] e, input int len);
      logic [AW-1:0] last;
      wr(1'b0, s);
      wr(1'b1, e);
      cmd = 2'b01;
      @(negedge clk);
      cmd = 2'b00;
      for (int i = 0; i < len; i++) begin
         chk(busy == 1'b1, "R5 busy during run", busy, 1);
         chk(imem_addr == AW'(s + i), "R4 address step", imem_addr, AW'(s + i));
         @(negedge clk);
      end
      last = AW'(s + len - 1);
      chk(busy == 1'b0, "R5 busy low after last", busy, 0);
      chk(done == 1'b1, "R10 done with busy fall", done, 1);
      chk(imem_addr == last, "R6 no wrap / R10 hold", imem_addr, last);
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", done, 0);
      chk(imem_addr == last, "R10 address held", imem_addr, last);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(busy == 1'b0, "R1 busy reset", busy, 0);
      chk(done == 1'b0, "R1 done reset", done, 0);
      chk(imem_addr == '0, "R1 addr reset", imem_addr, 0);
      chk(bus_retry == 1'b0, "R1 retry reset", bus_retry, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: default start/end are 0, so a start runs one cycle at address 0
      cmd = 2'b01;
      @(negedge clk);
      cmd = 2'b00;
      chk(busy && imem_addr == '0, "R1 default config", imem_addr, 0);
      @(negedge clk);
      chk(!busy && done, "R1 default one-cycle run", busy, 0);

      // R3 R4 R5 R6 table-driven runs
      foreach (VEC[k]) run(VEC[k][23:16], VEC[k][15:8], int'(VEC[k][7:0]));

      // R7 retry while busy and idle
      bus_req = 1'b1;
      @(negedge clk);
      chk(bus_retry == 1'b0, "R7 no retry idle", bus_retry, 0);
      wr(1'b0, 8'd40); wr(1'b1, 8'd45);
      cmd = 2'b01;
      @(negedge clk);
      cmd = 2'b00;
      chk(bus_retry == 1'b1, "R7 retry busy", bus_retry, 1);
      bus_req = 1'b0;
      @(negedge clk);
      chk(bus_retry == 1'b0, "R7 retry follows req", bus_retry, 0);
      while (busy) @(negedge clk);
      @(negedge clk);

      // R2 R9: writes and start while busy are ignored
      wr(1'b0, 8'd2); wr(1'b1, 8'd9);
      cmd = 2'b01;
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'd3;   // end write while busy
      @(negedge clk);
      cfg_sel = 1'b0; cfg_wdata = 8'd100;                   // start write while busy, start cmd held
      @(negedge clk);
      cfg_wr_en = 1'b0; cmd = 2'b00;
      chk(imem_addr == 8'd4, "R9 no reload on start", imem_addr, 4);
      for (int i = 0; i < 5; i++) @(negedge clk);
      chk(busy && imem_addr == 8'd9, "R2 end write ignored", imem_addr, 9);
      @(negedge clk);
      chk(!busy && done, "R2 run ends at stored end", busy, 0);
      cmd = 2'b01;
      @(negedge clk);
      cmd = 2'b00;
      chk(imem_addr == 8'd2, "R2 start write ignored", imem_addr, 2);
      while (busy) @(negedge clk);
      chk(imem_addr == 8'd9, "R2 next run end kept", imem_addr, 9);
      @(negedge clk);

      // R8 emergency stop
      wr(1'b0, 8'd4); wr(1'b1, 8'd50);
      cmd = 2'b01;
      @(negedge clk);
      cmd = 2'b00;
      @(negedge clk);
      @(negedge clk);
      chk(busy && imem_addr == 8'd6, "R8 pre-stop", imem_addr, 6);
      cmd = 2'b11;
      @(negedge clk);
      cmd = 2'b00;
      chk(busy == 1'b0, "R8 stop drops busy", busy, 0);
      chk(done == 1'b1, "R8 stop pulses done", done, 1);
      chk(imem_addr == 8'd6, "R8 address held", imem_addr, 6);
      @(negedge clk);
      cmd = 2'b01;
      @(negedge clk);
      cmd = 2'b00;
      chk(busy && imem_addr == 8'd4, "R8 restart", imem_addr, 4);
      @(negedge clk);
      chk(busy == 1'b0, "R8 end cleared one-cycle run", busy, 0);
      // R8 stop while idle: no done pulse
      @(negedge clk);
      cmd = 2'b11;
      @(negedge clk);
      cmd = 2'b00;
      chk(done == 1'b0, "R8 idle stop no done", done, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule